// File: doc/BRIEF.md
# Time-Slot Control Memory Access Controller

This block gives a processor indirect access to a per-time-slot control memory. Every memory entry pairs a 4-bit code field with an 8-bit data field. The code field sets the function of one time slot, and the meaning of the data field depends on that code. There are two banks of entries, one upstream and one downstream. The processor never addresses the memory directly. It loads an address register and a data register, then writes a command byte. The controller decodes the command, carries out one memory access and, for reads, places the result in the data register.

A code write moves the command's low nibble into the code field. In the same access it moves the data register into the data field. Use this form to assign, re-purpose or cancel a slot (code 0000), or to hand a slot to the processor (code 1001) with an idle byte. After a slot is set up, a data-only command reads or writes its data field alone. A code-read command returns the code in the low nibble of the data register.

A three-state sequencer (IDLE, EXEC, FINISH) runs each access. A command write that is accepted in IDLE takes the transition START to EXEC. In EXEC the memory access happens, and the transition COMMIT to FINISH applies the write or loads the read result. FINISH raises a one-cycle done pulse and takes the transition RELEASE back to IDLE. A command that is not recognised takes the transition HOLD, which stays in IDLE.

Top module: `cmi_ctrl`

## Requirements
- R1: After reset the data register and address register read 0x00, busy and done are low, and every entry in both banks holds code 0000 and data 0x00.
- R2: Register select `cpu_sel` picks a register: 0 is data, 1 is address, 2 is command. In the address register, bit 7 selects the bank (0 upstream, 1 downstream) and the low bits select the slot. Reads of select 2 or 3 return 0x00.
- R3: A command 0111cccc writes cccc to the code field of the addressed entry and the data register to its data field. The data register keeps its value.
- R4: Command 0xF0 loads the data register with {0000, code} of the addressed entry.
- R5: Command 0x48 writes the data register to the data field of the addressed entry. Command 0xC8 loads the data register from that data field. Bit 7 of these commands selects read (1) or write (0). Neither command changes the code field.
- R6: The two banks are independent. An access to one bank leaves the same slot in the other bank unchanged.
- R7: An accepted command raises busy on the following clock edge. Busy stays high for exactly two cycles, and done is high only in the second of them.
- R8: While busy is high, writes to any register are ignored.
- R9: A command byte outside the listed encodings is ignored. Busy stays low and no memory entry or register changes.
- R10: Code 1001 (processor access, with the data register stored as the idle byte) and code 0000 (unassigned) are stored and read back like any other code.
- R11: The highest slot number is reachable through the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | Register write strobe, one cycle per write |
| cpu_sel | input | 2 | Register select: 0 data, 1 address, 2 command |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse in the last busy cycle |

## Verification
The assertions assume that `cpu_we` is a synchronous strobe and that `cpu_sel` is stable in any cycle where the strobe is high. They also assume the processor does not depend on register writes made during busy taking effect. The stimulus drives every input on the falling edge, holds the strobe for exactly one cycle, and waits for busy to drop before the next command. The only exceptions are deliberate writes made during busy, which test that they are ignored.

// File: rtl/cmi_pkg.sv
package cmi_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_EXEC   = 2'd1,
        SEQ_FINISH = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_WR_DATA = 3'd1,
        OP_RD_DATA = 3'd2,
        OP_WR_CODE = 3'd3,
        OP_RD_CODE = 3'd4
    } cmi_op_t;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;

    localparam int CODE_W = 4;
    localparam int DATA_W = 8;

endpackage

// File: rtl/cmi_decode.sv
module cmi_decode
    import cmi_pkg::*;
(
    input  logic [7:0]        cmd,
    output cmi_op_t           op,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = cmd[3:0];
        op   = OP_NONE;
        if (cmd[7:4] == 4'b0111) begin
            op = OP_WR_CODE;
        end else if (cmd == 8'hF0) begin
            op = OP_RD_CODE;
        end else if (cmd[6:0] == 7'b1001000) begin
            // bit 7 chooses direction of the data-only access
            op = cmd[7] ? OP_RD_DATA : OP_WR_DATA;
        end
    end
endmodule

// File: rtl/cmi_seq.sv
module cmi_seq
    import cmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic exec
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        done    = 1'b0;
        exec    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start) state_d = SEQ_EXEC;    // START (else HOLD)
            end
            SEQ_EXEC: begin
                busy    = 1'b1;
                exec    = 1'b1;
                state_d = SEQ_FINISH;             // COMMIT
            end
            SEQ_FINISH: begin
                busy    = 1'b1;
                done    = 1'b1;
                state_d = SEQ_IDLE;               // RELEASE
            end
            default: state_d = SEQ_IDLE;
        endcase
    end
endmodule

// File: rtl/cmi_bank.sv
module cmi_bank
    import cmi_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int ADDR_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_code,
    input  logic              we_data,
    input  logic [ADDR_W-1:0] slot,
    input  logic [CODE_W-1:0] code_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out,
    output logic [DATA_W-1:0] data_out
);
    logic [CODE_W-1:0] code_mem [SLOTS];
    logic [DATA_W-1:0] data_mem [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                code_mem[i] <= '0;
                data_mem[i] <= '0;
            end
        end else begin
            if (we_code) code_mem[slot] <= code_in;
            if (we_data) data_mem[slot] <= data_in;
        end
    end

    assign code_out = code_mem[slot];
    assign data_out = data_mem[slot];
endmodule

// File: rtl/cmi_ctrl.sv
module cmi_ctrl
    import cmi_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_we,
    input  logic [1:0] cpu_sel,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       busy,
    output logic       done
);
    localparam int ADDR_W = $clog2(SLOTS);
    localparam int BANKS  = 2;

    logic [DATA_W-1:0] data_q;
    logic              bank_q;
    logic [ADDR_W-1:0] slot_q;
    cmi_op_t           op_q;
    logic [CODE_W-1:0] code_q;

    cmi_op_t           dec_op;
    logic [CODE_W-1:0] dec_code;
    logic              start, exec;

    logic [CODE_W-1:0] rd_code [BANKS];
    logic [DATA_W-1:0] rd_data [BANKS];

    cmi_decode u_decode (
        .cmd  (cpu_wdata),
        .op   (dec_op),
        .code (dec_code)
    );

    assign start = cpu_we && (cpu_sel == SEL_CMD) && !busy && (dec_op != OP_NONE);

    cmi_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .exec  (exec)
    );

    genvar b;
    generate
        for (b = 0; b < BANKS; b++) begin : g_bank
            logic hit;
            assign hit = exec && (bank_q == b[0]);
            cmi_bank #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .we_code  (hit && (op_q == OP_WR_CODE)),
                .we_data  (hit && (op_q == OP_WR_CODE || op_q == OP_WR_DATA)),
                .slot     (slot_q),
                .code_in  (code_q),
                .data_in  (data_q),
                .code_out (rd_code[b]),
                .data_out (rd_data[b])
            );
        end
    endgenerate

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            bank_q <= 1'b0;
            slot_q <= '0;
            op_q   <= OP_NONE;
            code_q <= '0;
        end else if (exec) begin
            if (op_q == OP_RD_DATA)      data_q <= rd_data[bank_q];
            else if (op_q == OP_RD_CODE) data_q <= {{(DATA_W-CODE_W){1'b0}}, rd_code[bank_q]};
        end else if (cpu_we && !busy) begin
            unique case (cpu_sel)
                SEL_DATA: data_q <= cpu_wdata;
                SEL_ADDR: begin
                    bank_q <= cpu_wdata[7];
                    slot_q <= cpu_wdata[ADDR_W-1:0];
                end
                SEL_CMD: begin
                    op_q   <= dec_op;
                    code_q <= dec_code;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_sel)
            SEL_DATA: cpu_rdata = data_q;
            SEL_ADDR: begin
                cpu_rdata[ADDR_W-1:0] = slot_q;
                cpu_rdata[7]          = bank_q;
            end
            default: cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmi_ctrl_chk.sv
module cmi_ctrl_chk
    import cmi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_we,
    input logic [1:0] cpu_sel,
    input logic       busy,
    input logic       done,
    input cmi_op_t    dec_op,
    input logic [7:0] data_q,
    input logic       bank_q
);
    logic wr_cmd;
    assign wr_cmd = cpu_we && (cpu_sel == SEL_CMD);

    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !busy && dec_op != OP_NONE) |=> (busy && !done));

    p_unknown_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !busy && dec_op == OP_NONE) |=> !busy);

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_sel == SEL_DATA && done) |=> $stable(data_q));

    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_sel == SEL_ADDR && busy) |=> $stable(bank_q));

    p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> done);
endmodule

bind cmi_ctrl cmi_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_we  (cpu_we),
    .cpu_sel (cpu_sel),
    .busy    (busy),
    .done    (done),
    .dec_op  (dec_op),
    .data_q  (data_q),
    .bank_q  (bank_q)
);

// File: tb/cmi_ctrl_tb.sv
`timescale 1ns/1ps
module cmi_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [1:0] cpu_sel = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       busy, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cmi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy), .done(done)
    );

    // {address, data, command, expected data register}
    localparam int NV = 17;
    localparam logic [31:0] VEC [NV] = '{
        {8'h03, 8'h5A, 8'h71, 8'h5A},  // R3 code+data write
        {8'h03, 8'h00, 8'hF0, 8'h01},  // R4 code read
        {8'h03, 8'h00, 8'hC8, 8'h5A},  // R5 data read
        {8'h83, 8'h00, 8'hF0, 8'h00},  // R6 other bank untouched code
        {8'h83, 8'h00, 8'hC8, 8'h00},  // R6 other bank untouched data
        {8'h83, 8'h9C, 8'h79, 8'h9C},  // R10 processor access idle byte
        {8'h83, 8'h00, 8'hC8, 8'h9C},  // R10 idle byte stored
        {8'h83, 8'h00, 8'hF0, 8'h09},  // R10 code 1001 stored
        {8'h03, 8'h33, 8'h48, 8'h33},  // R5 data-only write
        {8'h03, 8'h00, 8'hF0, 8'h01},  // R5 code unchanged
        {8'h03, 8'h00, 8'hC8, 8'h33},  // R5 new data
        {8'h1F, 8'hA5, 8'h7F, 8'hA5},  // R11 top slot
        {8'h1F, 8'h00, 8'hF0, 8'h0F},  // R11 top slot code
        {8'h03, 8'h00, 8'h70, 8'h00},  // R10 cancel
        {8'h03, 8'h00, 8'hF0, 8'h00},  // R10 code 0000
        {8'h03, 8'h11, 8'hC8, 8'h00},  // R10 data cleared by cancel
        {8'h83, 8'h00, 8'hF0, 8'h09}   // R6 bank 1 kept its code
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = val;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] val);
        cpu_sel = sel;
        #1;
        val = cpu_rdata;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, v); check("R1 data reg", v, 8'h00);
        reg_read(2'd1, v); check("R1 addr reg", v, 8'h00);
        check("R1 busy", {7'd0, busy}, 8'h00);
        check("R1 done", {7'd0, done}, 8'h00);
        reg_write(2'd1, 8'h85); reg_write(2'd0, 8'hFF); reg_write(2'd2, 8'hC8); wait_idle();
        reg_read(2'd0, v); check("R1 entry data", v, 8'h00);
        reg_write(2'd2, 8'hF0); wait_idle();
        reg_read(2'd0, v); check("R1 entry code", v, 8'h00);

        // R2 register map
        reg_write(2'd1, 8'h9E);
        reg_read(2'd1, v); check("R2 addr readback", v, 8'h9E);
        reg_read(2'd2, v); check("R2 sel2 reads 0", v, 8'h00);
        reg_read(2'd3, v); check("R2 sel3 reads 0", v, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd1, VEC[i][31:24]);
            reg_write(2'd0, VEC[i][23:16]);
            reg_write(2'd2, VEC[i][15:8]);
            wait_idle();
            reg_read(2'd0, v);
            check($sformatf("R3/R4/R5 vector %0d", i), v, VEC[i][7:0]);
        end

        // R7 busy/done timing
        reg_write(2'd1, 8'h05);
        reg_write(2'd0, 8'h44);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = 2'd2; cpu_wdata = 8'h76;
        @(negedge clk);
        cpu_we = 1'b0;
        check("R7 busy cycle 1", {6'd0, busy, done}, 8'h02);
        // R8 command during busy ignored
        cpu_we = 1'b1; cpu_sel = 2'd2; cpu_wdata = 8'h73;
        @(negedge clk);
        cpu_we = 1'b0;
        check("R7 busy cycle 2 done", {6'd0, busy, done}, 8'h03);
        @(negedge clk);
        check("R7 released", {6'd0, busy, done}, 8'h00);
        reg_write(2'd2, 8'hF0); wait_idle();
        reg_read(2'd0, v); check("R8 busy command ignored", v, 8'h06);

        // R8 data and address writes during busy ignored
        reg_write(2'd0, 8'h21);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = 2'd2; cpu_wdata = 8'h48;
        @(negedge clk);
        cpu_sel = 2'd0; cpu_wdata = 8'hBB;
        @(negedge clk);
        cpu_sel = 2'd1; cpu_wdata = 8'h87;
        @(negedge clk);
        cpu_we = 1'b0;
        wait_idle();
        reg_read(2'd0, v); check("R8 data write ignored", v, 8'h21);
        reg_read(2'd1, v); check("R8 addr write ignored", v, 8'h05);

        // R9 unrecognised command
        reg_write(2'd0, 8'h77);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = 2'd2; cpu_wdata = 8'h12;
        @(negedge clk);
        cpu_we = 1'b0;
        check("R9 no busy", {7'd0, busy}, 8'h00);
        reg_read(2'd0, v); check("R9 data reg kept", v, 8'h77);
        reg_write(2'd2, 8'hC8); wait_idle();
        reg_read(2'd0, v); check("R9 entry data kept", v, 8'h21);
        reg_write(2'd2, 8'hF0); wait_idle();
        reg_read(2'd0, v); check("R9 entry code kept", v, 8'h06);

        summary();
    end
endmodule